// File: doc/BRIEF.md
# Dual System Timer with Event Countdown and Free-Running Counter

This peripheral holds two independent counters behind a small 32-bit register bus. The first is a 56-bit countdown that raises an interrupt when it expires. It can fire once and then disarm itself, or it can reload its stored value and fire again with a fixed period. The second is a 64-bit counter that runs without stopping. Software reads it as two 32-bit words, low word first, and a shadow register keeps the two words consistent. Both counters advance only on cycles where the `tick_en` strobe is high, so a slow timebase such as 2 MHz can be produced by a divider outside the block.

To start the countdown, software writes the lower 32 bits of the load value to the load-low register. It then writes the control word, which carries the upper 24 load bits together with the enable, repeat and load bits. The counter takes the new value only on the control write. The interrupt output is the pending flag gated by a mask bit. The mask is changed through separate write-one-to-set and write-one-to-clear registers, and the pending flag is cleared by writing one to its own register.

Top module: `dual_tick_timer`

## Requirements
- R1: After reset `irq` is 0, the control register reads 0, and the free-running counter reads its reset value (parameter `FREE_INIT`, 0 by default).
- R2: Writing control (offset 0x004) with bit 30 set loads {control[23:0], load-low (0x000)} as the countdown value. With enable (bit 24) set and a load value N ≥ 2, the expiry happens on the Nth tick after the write and not before.
- R3: In one-shot mode (bit 28 clear), expiry clears the enable bit, so control reads bit 24 as 0. Later ticks produce no further expiry.
- R4: In repeat mode (bit 28 set), expiry reloads the stored value and enable stays set, so the next expiry follows N ticks later.
- R5: Expiry sets a pending flag. The flag stays set until a write with bit 0 = 1 to offset 0x034. If an expiry and that clear write happen in the same cycle, the expiry wins. `irq` equals pending AND mask, registered, and follows them one cycle later.
- R6: A write with bit 0 = 1 to offset 0x02C sets the mask. A write with bit 0 = 1 to offset 0x030 clears it. A write with bit 0 = 0 to either offset leaves the mask unchanged.
- R7: Writing 0 to control stops the countdown: later ticks cause no expiry.
- R8: The free-running counter adds one on each `tick_en` cycle and wraps modulo 2^64. It reads at offset 0x024 (bits 31:0) and offset 0x028 (bits 63:32).
- R9: A read of offset 0x024 copies the counter's upper 32 bits into a shadow register, and a read of offset 0x028 returns that shadow. Both values are taken at the same clock edge.
- R10: Read data appears on `bus_rdata` one cycle after `bus_rd`. Control reads return enable (bit 24), repeat (bit 28) and the stored upper load bits (23:0), with bit 30 reading 0. Offset 0x000 returns the stored load-low word. Unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count strobe for both counters |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Registered countdown interrupt |

## Verification
Read data is due at the first rising edge after the cycle in which `bus_rd` is high. The monitor records `bus_rd` at that edge and compares `bus_rdata` one time step later against the item the read task placed in the queue. An expiry sets pending at the edge of the Nth tick, and `irq` follows one edge later. A mask or clear write likewise reaches `irq` two edges after it is driven, so every interrupt check waits two full cycles after its stimulus. Ticks are issued one at a time by the bench, which keeps its own count of them. Reads happen only while `tick_en` is low, so the expected counter value is exact. Starting from a reset value just below 2^64 exercises the wrap and the high-word shadow with only a few ticks.

// File: rtl/dtt_pkg.sv
package dtt_pkg;
  localparam int DW = 32;

  // register byte offsets
  localparam int OFF_LOAD_LO  = 'h000;
  localparam int OFF_CTRL     = 'h004;
  localparam int OFF_FREE_LO  = 'h024;
  localparam int OFF_FREE_HI  = 'h028;
  localparam int OFF_MASK_SET = 'h02C;
  localparam int OFF_MASK_CLR = 'h030;
  localparam int OFF_PEND_CLR = 'h034;

  // control word bit positions
  localparam int CTRL_EN_BIT   = 24;
  localparam int CTRL_RPT_BIT  = 28;
  localparam int CTRL_LOAD_BIT = 30;

  typedef struct packed {
    logic wr_load_lo;
    logic wr_ctrl;
    logic wr_mask_set;
    logic wr_mask_clr;
    logic wr_pend_clr;
  } wr_dec_t;
endpackage

// File: rtl/dtt_event_timer.sv
module dtt_event_timer #(
  parameter int EV_W = 56,
  localparam int HI_W = EV_W - 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            wr_lo,
  input  logic            wr_ctrl,
  input  logic [31:0]     lo_data,
  input  logic [HI_W-1:0] hi_data,
  input  logic            en_in,
  input  logic            rpt_in,
  input  logic            load_in,
  output logic            enable,
  output logic            repeat_mode,
  output logic [HI_W-1:0] reload_hi,
  output logic [31:0]     reload_lo,
  output logic            expire
);
  logic [EV_W-1:0] cnt_q;
  logic            at_end;

  assign at_end = (cnt_q <= EV_W'(1));
  assign expire = tick && enable && !wr_ctrl && at_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_lo <= '0;
    end else if (wr_lo) begin
      reload_lo <= lo_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enable      <= 1'b0;
      repeat_mode <= 1'b0;
      reload_hi   <= '0;
      cnt_q       <= '0;
    end else if (wr_ctrl) begin
      enable      <= en_in;
      repeat_mode <= rpt_in;
      reload_hi   <= hi_data;
      if (load_in) cnt_q <= {hi_data, reload_lo};
    end else if (tick && enable) begin
      if (at_end) begin
        if (repeat_mode) begin
          cnt_q <= {reload_hi, reload_lo};
        end else begin
          cnt_q  <= '0;
          enable <= 1'b0;
        end
      end else begin
        cnt_q <= cnt_q - EV_W'(1);
      end
    end
  end
endmodule

// File: rtl/dtt_free_counter.sv
module dtt_free_counter #(
  parameter int          FREE_W    = 64,
  parameter logic [63:0] FREE_INIT = '0,
  localparam int UP_W = FREE_W - 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              rd_lo,
  output logic [FREE_W-1:0] count,
  output logic [UP_W-1:0]   shadow
);
  always_ff @(posedge clk) begin
    if (rst) begin
      count <= FREE_INIT[FREE_W-1:0];
    end else if (tick) begin
      count <= count + FREE_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= '0;
    end else if (rd_lo) begin
      shadow <= count[FREE_W-1:32];
    end
  end
endmodule

// File: rtl/dtt_irq_ctrl.sv
module dtt_irq_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic expire,
  input  logic set_mask,
  input  logic clr_mask,
  input  logic clr_pend,
  output logic mask,
  output logic pend,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask <= 1'b0;
      pend <= 1'b0;
      irq  <= 1'b0;
    end else begin
      if (set_mask)      mask <= 1'b1;
      else if (clr_mask) mask <= 1'b0;
      if (expire)        pend <= 1'b1;
      else if (clr_pend) pend <= 1'b0;
      irq <= pend & mask;
    end
  end
endmodule

// File: rtl/dual_tick_timer.sv
module dual_tick_timer
  import dtt_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          EV_W      = 56,
  parameter int          FREE_W    = 64,
  parameter logic [63:0] FREE_INIT = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  localparam int HI_W = EV_W - 32;
  localparam int UP_W = FREE_W - 32;

  wr_dec_t         wdec;
  logic            rd_free_lo;
  logic            ev_enable, ev_repeat, ev_expire;
  logic [HI_W-1:0] ev_hi;
  logic [31:0]     ev_lo;
  logic [FREE_W-1:0] free_cnt;
  logic [UP_W-1:0]   free_shadow;
  logic            irq_mask, irq_pend;

  always_comb begin
    wdec.wr_load_lo  = bus_wr && (bus_addr == ADDR_W'(OFF_LOAD_LO));
    wdec.wr_ctrl     = bus_wr && (bus_addr == ADDR_W'(OFF_CTRL));
    wdec.wr_mask_set = bus_wr && (bus_addr == ADDR_W'(OFF_MASK_SET));
    wdec.wr_mask_clr = bus_wr && (bus_addr == ADDR_W'(OFF_MASK_CLR));
    wdec.wr_pend_clr = bus_wr && (bus_addr == ADDR_W'(OFF_PEND_CLR));
  end
  assign rd_free_lo = bus_rd && (bus_addr == ADDR_W'(OFF_FREE_LO));

  dtt_event_timer #(.EV_W(EV_W)) u_event (
    .clk(clk), .rst(rst), .tick(tick_en),
    .wr_lo(wdec.wr_load_lo), .wr_ctrl(wdec.wr_ctrl),
    .lo_data(bus_wdata), .hi_data(bus_wdata[HI_W-1:0]),
    .en_in(bus_wdata[CTRL_EN_BIT]), .rpt_in(bus_wdata[CTRL_RPT_BIT]),
    .load_in(bus_wdata[CTRL_LOAD_BIT]),
    .enable(ev_enable), .repeat_mode(ev_repeat),
    .reload_hi(ev_hi), .reload_lo(ev_lo), .expire(ev_expire)
  );

  dtt_free_counter #(.FREE_W(FREE_W), .FREE_INIT(FREE_INIT)) u_free (
    .clk(clk), .rst(rst), .tick(tick_en), .rd_lo(rd_free_lo),
    .count(free_cnt), .shadow(free_shadow)
  );

  dtt_irq_ctrl u_irq (
    .clk(clk), .rst(rst), .expire(ev_expire),
    .set_mask(wdec.wr_mask_set && bus_wdata[0]),
    .clr_mask(wdec.wr_mask_clr && bus_wdata[0]),
    .clr_pend(wdec.wr_pend_clr && bus_wdata[0]),
    .mask(irq_mask), .pend(irq_pend), .irq(irq)
  );

  logic [31:0] ctrl_view;
  always_comb begin
    ctrl_view = '0;
    ctrl_view[HI_W-1:0]    = ev_hi;
    ctrl_view[CTRL_EN_BIT] = ev_enable;
    ctrl_view[CTRL_RPT_BIT]= ev_repeat;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        ADDR_W'(OFF_LOAD_LO): bus_rdata <= ev_lo;
        ADDR_W'(OFF_CTRL):    bus_rdata <= ctrl_view;
        ADDR_W'(OFF_FREE_LO): bus_rdata <= free_cnt[31:0];
        ADDR_W'(OFF_FREE_HI): bus_rdata <= 32'(free_shadow);
        default:              bus_rdata <= '0;
      endcase
    end else begin
      bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/dtt_checker.sv
module dtt_checker #(
  parameter int FREE_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              irq,
  input logic              expire,
  input logic              ev_enable,
  input logic              ev_repeat,
  input logic              pend,
  input logic              mask,
  input logic              ctrl_wr,
  input logic              pclr_wr,
  input logic [31:0]       wdata,
  input logic              lo_rd,
  input logic [FREE_W-1:0] free_cnt,
  input logic [FREE_W-33:0] shadow
);
  AST_RESET_QUIET: assert property (@(posedge clk) $past(rst) |-> !irq); // R1
  AST_ONESHOT_DISARM: assert property (@(posedge clk) disable iff (rst)
    (expire && !ev_repeat) |=> !ev_enable); // R3
  AST_REPEAT_STAYS: assert property (@(posedge clk) disable iff (rst)
    (expire && ev_repeat) |=> ev_enable); // R4
  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (rst)
    (pend && !(pclr_wr && wdata[0])) |=> pend); // R5
  AST_MASK_GATES: assert property (@(posedge clk) disable iff (rst)
    !mask |=> !irq); // R6
  AST_STOP_WRITE: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && wdata == 32'h0) |=> !ev_enable); // R7
  AST_FREE_STEP: assert property (@(posedge clk) disable iff (rst)
    tick |=> free_cnt == $past(free_cnt) + FREE_W'(1)); // R8
  AST_FREE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(free_cnt)); // R8
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    !lo_rd |=> $stable(shadow)); // R9
endmodule

bind dual_tick_timer dtt_checker #(.FREE_W(FREE_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick_en), .irq(irq),
  .expire(ev_expire), .ev_enable(ev_enable), .ev_repeat(ev_repeat),
  .pend(irq_pend), .mask(irq_mask), .ctrl_wr(wdec.wr_ctrl),
  .pclr_wr(wdec.wr_pend_clr), .wdata(bus_wdata), .lo_rd(rd_free_lo),
  .free_cnt(free_cnt), .shadow(free_shadow)
);

// File: tb/test_dual_tick_timer.sv
module test_dual_tick_timer;
  localparam logic [63:0] INIT = 64'hFFFF_FFFF_FFFF_FFF8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int ticks  = 0;
  logic [63:0] shadow_exp;

  typedef struct { logic [31:0] v; string tag; } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  dual_tick_timer #(.FREE_INIT(INIT)) i_dual_tick_timer (
    .clk(clk), .rst(rst), .tick_en(tick_en), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // monitor: read data due one edge after bus_rd
  always @(posedge clk) begin
    automatic logic was_rd = bus_rd;
    #1;
    if (was_rd && !rst) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10: unexpected read result %h", bus_rdata);
      end else begin
        automatic exp_t e = exp_q.pop_front();
        checks++;
        if (bus_rdata !== e.v) begin
          errors++;
          $display("FAIL %s: rdata=%h expected=%h", e.tag, bus_rdata, e.v);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [7:0] a, input logic [31:0] e, input string tag);
    exp_t it;
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    it.v = e; it.tag = tag; exp_q.push_back(it);
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic do_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
      ticks++;
    end
  endtask

  task automatic check_irq(input logic e, input string tag);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s: irq=%b expected=%b", tag, irq, e);
    end
  endtask

  function automatic logic [63:0] free_now();
    return INIT + 64'(ticks);
  endfunction

  initial begin
    #(20 * 100000);
    errors++; checks++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3); rst = 1'b0; idle(1);
    check_irq(1'b0, "R1 reset irq");
    bus_read(8'h04, 32'h0, "R1 reset ctrl");
    // low read latches high word, then counter wraps past 2^64
    bus_read(8'h24, free_now()[31:0], "R1 R9 free low at reset");
    shadow_exp = free_now();
    do_ticks(10);
    bus_read(8'h28, shadow_exp[63:32], "R9 high returns shadow");
    bus_read(8'h24, free_now()[31:0], "R8 low after wrap");
    bus_read(8'h28, free_now()[63:32], "R8 high after wrap");

    // one-shot, N=3
    bus_write(8'h2C, 32'h1);
    bus_write(8'h00, 32'd3);
    bus_write(8'h04, 32'h4100_0000);
    do_ticks(2); idle(2);
    check_irq(1'b0, "R2 not before Nth tick");
    do_ticks(1); idle(2);
    check_irq(1'b1, "R2 expiry on Nth tick");
    bus_read(8'h04, 32'h0, "R3 enable cleared");
    bus_write(8'h34, 32'h1); idle(2);
    check_irq(1'b0, "R5 pending cleared");
    do_ticks(4); idle(2);
    check_irq(1'b0, "R3 no further expiry");

    // control readback without load, then stop
    bus_write(8'h04, 32'h1000_0012);
    bus_read(8'h04, 32'h1000_0012, "R10 ctrl readback");
    bus_write(8'h04, 32'h0);
    bus_read(8'h04, 32'h0, "R7 ctrl zero");

    // repeat, N=2
    bus_write(8'h00, 32'd2);
    bus_write(8'h04, 32'h5100_0000);
    do_ticks(2); idle(2);
    check_irq(1'b1, "R4 first expiry");
    bus_write(8'h34, 32'h1); idle(2);
    check_irq(1'b0, "R5 cleared");
    do_ticks(1); idle(2);
    check_irq(1'b0, "R4 not yet reloaded expiry");
    do_ticks(1); idle(2);
    check_irq(1'b1, "R4 reload expiry");
    bus_read(8'h04, 32'h1100_0000, "R4 enable stays");

    // mask behaviour with pending held
    bus_write(8'h30, 32'h0); idle(2);
    check_irq(1'b1, "R6 zero to mask-clear ignored");
    bus_write(8'h30, 32'h1); idle(2);
    check_irq(1'b0, "R6 mask cleared");
    bus_write(8'h2C, 32'h0); idle(2);
    check_irq(1'b0, "R6 zero to mask-set ignored");
    bus_write(8'h2C, 32'h1); idle(2);
    check_irq(1'b1, "R5 pending held while masked");
    bus_write(8'h34, 32'h0); idle(2);
    check_irq(1'b1, "R5 zero to clear ignored");

    // stop by zero write
    bus_write(8'h04, 32'h0);
    bus_write(8'h34, 32'h1);
    do_ticks(5); idle(2);
    check_irq(1'b0, "R7 stopped timer silent");

    bus_read(8'h10, 32'h0, "R10 unmapped zero");
    bus_read(8'h08, 32'h0, "R10 unmapped zero 2");
    bus_read(8'h00, 32'd2, "R10 load-low readback");
    bus_read(8'h24, free_now()[31:0], "R8 final low");
    bus_read(8'h28, free_now()[63:32], "R8 R9 final high");
    idle(3);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R10: %0d reads unanswered, expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule